// File: doc/BRIEF.md
# Pixel Hit Registration and Ping-Pong Event Counter

This block is the digital back end of one imaging pixel. A discriminator pulse arrives on `disc_i`. It is synchronized into the pixel clock domain, and each rising edge of it increments an event counter. The first rising edge in a time frame also marks the pixel as hit. Frame boundaries come from `frame_i`. At each boundary the hit mark moves from a waiting stage into a service stage. The service stage asks the group sparsifier for readout through `req_o`.

Two counters alternate. One counts the current frame while the other holds the closed frame until the sparsifier grants the pixel and reads it. Acquisition therefore never stops during readout. While the pixel is granted, its held count appears on a group data lane. The lane is modelled as an enable plus a value that is zero when idle, so that a group can OR its pixels together. A rising edge on `strobe_i` during the grant completes the readout.

Two configuration bits override real hits. A force-set bit makes the pixel request every frame. A force-exclude bit silences the pixel. Force-set wins when both are 1.

Top module: `pixel_hit_ctr`

## Requirements
- R1: The first rising edge of the synchronized discriminator in a frame sets the waiting stage. The pixel then requests readout after the next rising edge of `frame_i`.
- R2: A rising edge of `frame_i` moves the waiting stage into the service stage and clears the waiting stage. A discriminator rising edge in the same clock cycle is counted in the new frame and sets the waiting stage again.
- R3: A discriminator that is still high at a frame boundary is not counted again in the new frame. A new count needs a falling edge and then a new rising edge.
- R4: `req_o` follows the service stage and stays high until a rising edge of `strobe_i` occurs while `grant_i` is high.
- R5: With `force_set_i`=1, the pixel requests at every frame boundary. If the closed frame had no hits, it reports a count of 0.
- R6: With `force_excl_i`=1 and `force_set_i`=0, `req_o` never rises. With both bits at 1, force-set wins.
- R7: Two CNT_W-bit counters alternate. The held counter keeps the closed frame's count for readout. Hits that arrive during that readout are counted in the other counter.
- R8: The counters swap roles at a frame boundary only if the closed frame had a hit or force-set is 1. The counter that becomes the counting one starts at zero, or at 1 if a hit coincides with the boundary.
- R9: Counters have no saturation. They wrap modulo 2^CNT_W, so 33 hits read as 1 and 32 hits read as 0 when CNT_W=5.
- R10: `bus_en_o` is high and `bus_data_o` carries the held count only while the pixel requests and is granted. Otherwise `bus_data_o` is 0. The drive ends in the cycle after the rising strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disc_i | input | 1 | Asynchronous discriminator output |
| frame_i | input | 1 | Frame clock; a rising edge closes a frame (synchronous to clk_i) |
| strobe_i | input | 1 | Readout strobe; a rising edge ends a pixel's readout |
| grant_i | input | 1 | Sparsifier grant to this pixel |
| force_set_i | input | 1 | Force a request every frame |
| force_excl_i | input | 1 | Exclude the pixel from readout |
| req_o | output | 1 | Readout request to the sparsifier |
| bus_en_o | output | 1 | Group lane drive enable |
| bus_data_o | output | CNT_W | Held count while driving, else 0 |

## Verification
The bench uses CNT_W=5 and SYNC_STAGES=2. With a 5-bit counter, wrap-around takes only 32 or 33 pulses, so the modulo behaviour is reached in a short run. With a two-flop synchronizer, the latency is known, so a discriminator edge can be placed in exactly the cycle of a frame edge to test the coincidence rule. Readouts are granted only after a delay, and further hits are injected during that delay. This shows that the held count is unaffected by hits in the new frame.

// File: rtl/pix_pkg.sv
package pix_pkg;
  typedef struct packed {
    logic hit;     // synchronized discriminator rising edge
    logic frame;   // frame clock rising edge
    logic strobe;  // readout strobe rising edge
  } pix_evt_t;
endpackage

// File: rtl/pix_front.sv
module pix_front
  import pix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     disc_i,
  input  logic     frame_i,
  input  logic     strobe_i,
  output pix_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic disc_q, frame_q, strobe_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= disc_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q   <= 1'b0;
      frame_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      disc_q   <= sync_q[SYNC_STAGES-1];
      frame_q  <= frame_i;
      strobe_q <= strobe_i;
    end
  end

  // edge-only hit detection: a level held across a frame edge is never re-counted
  assign evt_o.hit    = sync_q[SYNC_STAGES-1] & ~disc_q;
  assign evt_o.frame  = frame_i & ~frame_q;
  assign evt_o.strobe = strobe_i & ~strobe_q;
endmodule

// File: rtl/pix_hit_pipe.sv
module pix_hit_pipe
  import pix_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pix_evt_t evt_i,
  input  logic     grant_i,
  input  logic     set_i,
  input  logic     excl_i,
  output logic     req_o,
  output logic     swap_o
);
  logic wait_q, svc_q, allow;

  assign allow = set_i | ~excl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      // new hit wins over the frame-edge clear
      if (evt_i.hit)        wait_q <= 1'b1;
      else if (evt_i.frame) wait_q <= 1'b0;

      if (evt_i.frame && (wait_q || set_i) && allow) svc_q <= 1'b1;
      else if (evt_i.strobe && grant_i)              svc_q <= 1'b0;
    end
  end

  assign req_o  = svc_q & allow;
  assign swap_o = evt_i.frame & (wait_q | set_i);

  // R1
  hit_sets_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.hit |=> wait_q);
  // R2
  frame_clears_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.frame && !evt_i.hit) |=> !wait_q);
  // R4
  strobe_clears_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.strobe && grant_i && svc_q && !evt_i.frame) |=> !svc_q);
  // R4
  svc_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q && !evt_i.strobe) |=> svc_q);
endmodule

// File: rtl/pix_ctr_pair.sv
module pix_ctr_pair #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             swap_i,
  output logic [CNT_W-1:0] held_o
);
  localparam int NBANK = 2;
  logic [CNT_W-1:0] ctr_q [NBANK];
  logic             sel_q;
  logic [CNT_W-1:0] cnt_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (swap_i) sel_q <= ~sel_q;
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctr_q[b] <= '0;
        else if (swap_i) begin
          // bank taking over counting restarts; old counting bank freezes
          if (sel_q != 1'(b)) ctr_q[b] <= hit_i ? CNT_W'(1) : '0;
        end else if (sel_q == 1'(b) && hit_i) begin
          ctr_q[b] <= ctr_q[b] + 1'b1;
        end
      end
    end
  endgenerate

  assign cnt_cur = ctr_q[sel_q];
  assign held_o  = ctr_q[~sel_q];

  // R9
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !swap_i && cnt_cur == '1) |=> cnt_cur == '0);
  // R8
  no_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(sel_q));
  // R7
  swap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> held_o == $past(cnt_cur));
  // R7
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(held_o));
endmodule

// File: rtl/pixel_hit_ctr.sv
module pixel_hit_ctr
  import pix_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disc_i,
  input  logic             frame_i,
  input  logic             strobe_i,
  input  logic             grant_i,
  input  logic             force_set_i,
  input  logic             force_excl_i,
  output logic             req_o,
  output logic             bus_en_o,
  output logic [CNT_W-1:0] bus_data_o
);
  pix_evt_t         evt;
  logic             swap;
  logic [CNT_W-1:0] held;

  pix_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .disc_i, .frame_i, .strobe_i, .evt_o(evt)
  );

  pix_hit_pipe u_pipe (
    .clk_i, .rst_ni, .evt_i(evt), .grant_i,
    .set_i(force_set_i), .excl_i(force_excl_i),
    .req_o, .swap_o(swap)
  );

  pix_ctr_pair #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .hit_i(evt.hit), .swap_i(swap), .held_o(held)
  );

  // lane modelled as enable plus zero-when-idle value for OR-combining
  assign bus_en_o   = req_o & grant_i;
  assign bus_data_o = bus_en_o ? held : '0;

  // R10
  drive_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.strobe && grant_i && !evt.frame) |=> !bus_en_o);
  // R6
  excl_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_excl_i && !force_set_i && !req_o) |=> !req_o || !$past(force_excl_i && !force_set_i));
endmodule

// File: tb/pixel_hit_ctr_bench.sv
module pixel_hit_ctr_bench;
  localparam int CNT_W = 5;
  localparam int MODV  = 1 << CNT_W;

  logic clk = 0, rst_ni = 0;
  logic disc = 0, frame = 0, strobe = 0, grant = 0, fset = 0, fexcl = 0;
  logic req, bus_en;
  logic [CNT_W-1:0] bus_data;

  int tests = 0, fails = 0;
  int exp_q[$];
  int tag_q[$];
  int m_cnt = 0;
  bit m_hit = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixel_hit_ctr #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_pixel_hit_ctr (
    .clk_i(clk), .rst_ni, .disc_i(disc), .frame_i(frame), .strobe_i(strobe),
    .grant_i(grant), .force_set_i(fset), .force_excl_i(fexcl),
    .req_o(req), .bus_en_o(bus_en), .bus_data_o(bus_data)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit_pulse();
    disc = 1; ticks(3);
    disc = 0; ticks(3);
    m_cnt = (m_cnt + 1) % MODV; m_hit = 1;
  endtask

  // frame model: R5 R6 R8
  task automatic close_frame_model(input int tag);
    if (m_hit || fset) begin
      if (fset || !fexcl) begin exp_q.push_back(m_cnt); tag_q.push_back(tag); end
      m_cnt = 0; m_hit = 0;
    end
  endtask

  task automatic frame_pulse(input int tag);
    close_frame_model(tag);
    frame = 1; ticks(1);
    frame = 0; ticks(1);
  endtask

  task automatic settle_quiet(input string req_tag);
    ticks(12);
    chk(req == 0, req_tag, req, 0);
  endtask

  // monitor: grant after a delay, compare lane, strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected request", 1, 0);
          grant = 1; ticks(1); strobe = 1; ticks(1); strobe = 0; grant = 0;
        end else begin
          int e, t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(bus_en == 0 && bus_data == 0, "R10 idle lane before grant", bus_data, 0);
          ticks(3);
          chk(req == 1, "R4 request held until served", req, 1);
          grant = 1; ticks(1);
          chk(bus_en == 1, "R10 drive while granted", bus_en, 1);
          tests++;
          if (bus_data !== CNT_W'(e)) begin
            fails++;
            $display("FAIL R%0d count actual=%0d expected=%0d", t, bus_data, e);
          end
          strobe = 1; ticks(1);
          chk(bus_en == 0 && req == 0, "R10 R4 released after strobe", bus_en, 0);
          strobe = 0; grant = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    ticks(3);
    chk(req == 0 && bus_en == 0 && bus_data == 0, "reset state", req, 0);
    rst_ni = 1; ticks(3);

    // R1: three hits -> 3
    repeat (3) hit_pulse();
    frame_pulse(1); ticks(20);
    // R1 single hit
    hit_pulse(); frame_pulse(1); ticks(20);
    // R8 empty frame: no request
    frame_pulse(8); settle_quiet("R8 empty frame");

    // R3: level held across frame edge counted once
    repeat (2) hit_pulse();
    disc = 1; ticks(3);
    m_cnt = (m_cnt + 1) % MODV; m_hit = 1;
    frame_pulse(3);
    ticks(4); disc = 0; ticks(20);
    frame_pulse(3); settle_quiet("R3 no recount after boundary");

    // R2: hit coincident with frame edge lands in new frame
    repeat (2) hit_pulse();
    disc = 1; ticks(2);
    close_frame_model(2);
    m_cnt = 1; m_hit = 1;
    frame = 1; ticks(1); frame = 0; ticks(2);
    disc = 0; ticks(20);
    frame_pulse(2); ticks(20);

    // R9 wrap
    repeat (33) hit_pulse();
    frame_pulse(9); ticks(20);
    repeat (32) hit_pulse();
    frame_pulse(9); ticks(20);

    // R7 hits during readout of previous frame
    repeat (3) hit_pulse();
    frame_pulse(7);
    repeat (2) hit_pulse();
    ticks(20);
    frame_pulse(7); ticks(20);

    // R5 force set
    fset = 1;
    frame_pulse(5); ticks(20);
    repeat (4) hit_pulse();
    frame_pulse(5); ticks(20);
    fset = 0;

    // R6 exclude
    fexcl = 1;
    repeat (5) hit_pulse();
    frame_pulse(6); settle_quiet("R6 excluded pixel silent");
    fset = 1;
    repeat (2) hit_pulse();
    frame_pulse(6); ticks(20);
    fset = 0;
    frame_pulse(6); settle_quiet("R6 excluded empty frame");
    fexcl = 0;
    frame_pulse(8); settle_quiet("R8 no stale request after exclude");

    ticks(10);
    chk(exp_q.size() == 0, "R4 all expected readouts served", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule